// File: doc/BRIEF.md
# Length-Addressed Serial Configuration Registers

This block is the serial configuration front end of a frequency synthesizer's divider section. A host writes it over a three-wire serial link: a data line, a serial clock and an active-high enable framing each transfer. Bits are taken most significant first on each rising serial clock edge while the enable is high. No address travels with the data. When the enable drops, the number of bits received selects the target: 8 bits write the control word, 16 bits write the reference ratio word, and 24 bits write the main ratio word. A transfer of any other length is thrown away. A serial output shows the far end of the 24-bit shift chain, so that devices can be chained.

The control word takes effect as soon as the transfer ends. The reference and main ratio words are double-buffered. Each written value waits in a pending buffer and moves to the active register only when the divider logic reports a load boundary. Each ratio word has a valid/ready pair: `*_pending` is the valid and the divider's ready input is the ready. A value is taken in a cycle where both are high. While ready stays low, the pending value waits with no time limit. A second write before the handshake replaces the pending value, and only the last one is taken. If both ratio words are pending, they are handed over only together, in one cycle in which both readies are high. This lets the divider counters see the new reference and main ratios at the same instant.

The serial pins are sampled in the system clock domain through a synchronizer, so the serial clock must run well below the system clock.

Top module: `lenaddr_cfg`

## Requirements
- R1: After reset, `c_word`, `r_word` and `a_word` are zero, `r_pending` and `a_pending` are low, and `sdo` is low.
- R2: A transfer of exactly 8 bits writes `c_word` directly, with the first bit sent landing in bit 7, and it sets no pending flag.
- R3: A transfer of exactly 16 bits raises `r_pending`, and `r_word` keeps its old value for as long as `r_ready` is low.
- R4: A transfer of exactly 24 bits raises `a_pending`, and `a_word` keeps its old value for as long as `an_ready` is low. When `an_ready` is high, the pending value moves to `a_word` and `a_pending` drops.
- R5: A transfer of any other length (0, 2, 7, 9 or 25 bits) leaves all three words and both pending flags unchanged.
- R6: While both ratio words are pending, neither is taken until `an_ready` and `r_ready` are both high. Both are then taken in the same cycle.
- R7: A second write to a pending ratio word before its handshake replaces the pending value, and only the last value reaches the active word.
- R8: `sdo` is the most significant bit of the 24-bit shift chain. A bit appears there after 24 rising serial clock edges have passed, and each further edge moves the chain one place.
- R9: Serial clock edges while `sen` is low shift nothing and write nothing.
- R10: `a_commit` and `r_commit` are single-cycle pulses, high only in the first cycle in which the active word holds the newly taken value, and only after a cycle in which that word was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data in, most significant bit first |
| sen | input | 1 | Transfer enable, active high; its falling edge ends a transfer |
| sdo | output | 1 | Far end of the shift chain, for chaining devices |
| c_word | output | 8 | Active control word |
| r_word | output | 16 | Active reference ratio word |
| a_word | output | 24 | Active main ratio word |
| r_pending | output | 1 | Valid: a reference ratio value waits for handover |
| r_ready | input | 1 | Ready: the reference counter is at a load boundary |
| r_commit | output | 1 | Pulse: `r_word` has just taken a new value |
| a_pending | output | 1 | Valid: a main ratio value waits for handover |
| an_ready | input | 1 | Ready: the main and swallow counters are at a load boundary |
| a_commit | output | 1 | Pulse: `a_word` has just taken a new value |

## Verification
The bench builds the block with the default widths of 8, 16 and 24 bits and two synchronizer stages. With these widths the three legal lengths sit far enough apart that a one-bit slip in the counter lands on a discarded length, so a miscount is visible at the word outputs. Two synchronizer stages leave the serial clock at one eighth of the system clock with margin. The single 24-bit chain makes the `sdo` position after 24 edges and after two more edges something the bench can predict.

// File: rtl/lenaddr_cfg_pkg.sv
package lenaddr_cfg_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CTRL = 2'd1,
    TGT_REF  = 2'd2,
    TGT_MAIN = 2'd3
  } tgt_e;
endpackage

// File: rtl/lenaddr_cfg_sync.sv
module lenaddr_cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st [0:STAGES];
  assign st[0] = din;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i+1] <= '0;
      else        st[i+1] <= st[i];
    end
  end

  assign dout = st[STAGES];
endmodule

// File: rtl/lenaddr_cfg_shift.sv
module lenaddr_cfg_shift
  import lenaddr_cfg_pkg::*;
#(
  parameter int C_W = 8,
  parameter int R_W = 16,
  parameter int A_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_sclk,
  input  logic           s_sdi,
  input  logic           s_sen,
  output logic [A_W-1:0] chain,
  output tgt_e           tgt,
  output logic           wr_stb
);
  localparam int CNT_W = $clog2(A_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic           sclk_q, sen_q;
  logic [CNT_W-1:0] cnt;
  logic           rise, en_rise, en_fall;

  assign rise    = s_sclk & ~sclk_q & s_sen;
  assign en_rise = s_sen & ~sen_q;
  assign en_fall = ~s_sen & sen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sen_q  <= 1'b0;
      cnt    <= '0;
      chain  <= '0;
      tgt    <= TGT_NONE;
      wr_stb <= 1'b0;
    end else begin
      sclk_q <= s_sclk;
      sen_q  <= s_sen;
      wr_stb <= 1'b0;
      if (en_rise) begin
        cnt <= '0;
      end else if (rise) begin
        chain <= {chain[A_W-2:0], s_sdi};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (en_fall) begin
        wr_stb <= 1'b1;
        if (cnt == CNT_W'(C_W))      tgt <= TGT_CTRL;
        else if (cnt == CNT_W'(R_W)) tgt <= TGT_REF;
        else if (cnt == CNT_W'(A_W)) tgt <= TGT_MAIN;
        else                         tgt <= TGT_NONE;
      end
    end
  end
endmodule

// File: rtl/lenaddr_cfg_commit.sv
module lenaddr_cfg_commit
  import lenaddr_cfg_pkg::*;
#(
  parameter int C_W = 8,
  parameter int R_W = 16,
  parameter int A_W = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] word,
  input  tgt_e           tgt,
  input  logic           wr_stb,
  input  logic           r_ready,
  input  logic           an_ready,
  output logic [C_W-1:0] c_act,
  output logic [R_W-1:0] r_act,
  output logic [A_W-1:0] a_act,
  output logic           r_pv,
  output logic           a_pv,
  output logic           r_stb,
  output logic           a_stb
);
  logic [R_W-1:0] r_buf;
  logic [A_W-1:0] a_buf;
  logic wr_c, wr_r, wr_a;
  logic pair_go, a_go, r_go, a_fire, r_fire;

  assign wr_c = wr_stb && (tgt == TGT_CTRL);
  assign wr_r = wr_stb && (tgt == TGT_REF);
  assign wr_a = wr_stb && (tgt == TGT_MAIN);

  assign pair_go = a_pv && r_pv && an_ready && r_ready;
  assign a_go    = a_pv && !r_pv && an_ready;
  assign r_go    = r_pv && !a_pv && r_ready;
  assign a_fire  = pair_go || a_go;
  assign r_fire  = pair_go || r_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_act <= '0;
      r_act <= '0;
      a_act <= '0;
      r_buf <= '0;
      a_buf <= '0;
      r_pv  <= 1'b0;
      a_pv  <= 1'b0;
      r_stb <= 1'b0;
      a_stb <= 1'b0;
    end else begin
      r_stb <= r_fire;
      a_stb <= a_fire;
      if (wr_c)   c_act <= word[C_W-1:0];
      if (r_fire) r_act <= r_buf;
      if (a_fire) a_act <= a_buf;
      if (wr_r) begin
        r_buf <= word[R_W-1:0];
        r_pv  <= 1'b1;
      end else if (r_fire) begin
        r_pv  <= 1'b0;
      end
      if (wr_a) begin
        a_buf <= word;
        a_pv  <= 1'b1;
      end else if (a_fire) begin
        a_pv  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lenaddr_cfg.sv
module lenaddr_cfg
  import lenaddr_cfg_pkg::*;
#(
  parameter int C_W         = 8,
  parameter int R_W         = 16,
  parameter int A_W         = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk,
  input  logic           sdi,
  input  logic           sen,
  output logic           sdo,
  output logic [C_W-1:0] c_word,
  output logic [R_W-1:0] r_word,
  output logic [A_W-1:0] a_word,
  output logic           r_pending,
  input  logic           r_ready,
  output logic           r_commit,
  output logic           a_pending,
  input  logic           an_ready,
  output logic           a_commit
);
  logic [2:0]     s_pins;
  logic [A_W-1:0] chain;
  tgt_e           tgt;
  logic           wr_stb;

  lenaddr_cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sclk, sdi, sen}),
    .dout (s_pins)
  );

  lenaddr_cfg_shift #(.C_W(C_W), .R_W(R_W), .A_W(A_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .s_sclk(s_pins[2]),
    .s_sdi (s_pins[1]),
    .s_sen (s_pins[0]),
    .chain (chain),
    .tgt   (tgt),
    .wr_stb(wr_stb)
  );

  lenaddr_cfg_commit #(.C_W(C_W), .R_W(R_W), .A_W(A_W)) u_commit (
    .clk     (clk),
    .rst_n   (rst_n),
    .word    (chain),
    .tgt     (tgt),
    .wr_stb  (wr_stb),
    .r_ready (r_ready),
    .an_ready(an_ready),
    .c_act   (c_word),
    .r_act   (r_word),
    .a_act   (a_word),
    .r_pv    (r_pending),
    .a_pv    (a_pending),
    .r_stb   (r_commit),
    .a_stb   (a_commit)
  );

  assign sdo = chain[A_W-1];
endmodule

// File: rtl/lenaddr_cfg_chk.sv
module lenaddr_cfg_chk #(
  parameter int R_W = 16,
  parameter int A_W = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic [R_W-1:0] r_word,
  input logic [A_W-1:0] a_word,
  input logic           r_pending,
  input logic           r_ready,
  input logic           r_commit,
  input logic           a_pending,
  input logic           an_ready,
  input logic           a_commit
);
  // R3: no reference handover without ready
  p_r_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !r_ready |=> $stable(r_word));
  // R4: no main handover without ready
  p_a_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !an_ready |=> $stable(a_word));
  // R6: both pending means both are handed over together
  p_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_pending && r_pending) |=> (a_commit == r_commit));
  // R10: a pulse follows a pending cycle
  p_a_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    a_commit |-> $past(a_pending));
  p_r_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    r_commit |-> $past(r_pending));
  // R10: pulses last one cycle while nothing is pending again
  p_a_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_commit && !a_pending) |=> !a_commit);
endmodule

bind lenaddr_cfg lenaddr_cfg_chk #(.R_W(R_W), .A_W(A_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .r_word   (r_word),
  .a_word   (a_word),
  .r_pending(r_pending),
  .r_ready  (r_ready),
  .r_commit (r_commit),
  .a_pending(a_pending),
  .an_ready (an_ready),
  .a_commit (a_commit)
);

// File: tb/lenaddr_cfg_test.sv
`timescale 1ns/1ps
module lenaddr_cfg_test;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdi = 0, sen = 0, r_ready = 1, an_ready = 1;
  logic sdo, r_pending, r_commit, a_pending, a_commit;
  logic [7:0] c_word;
  logic [15:0] r_word;
  logic [23:0] a_word;
  int checks = 0, failures = 0;
  int a_cnt = 0, r_cnt = 0, pair_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lenaddr_cfg uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .sen(sen), .sdo(sdo),
    .c_word(c_word), .r_word(r_word), .a_word(a_word),
    .r_pending(r_pending), .r_ready(r_ready), .r_commit(r_commit),
    .a_pending(a_pending), .an_ready(an_ready), .a_commit(a_commit)
  );

  always @(negedge clk) begin
    if (a_commit) a_cnt++;
    if (r_commit) r_cnt++;
    if (a_commit && r_commit) pair_cnt++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int n, logic [31:0] v);
    sen = 1; cyc(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i]; cyc(4);
      sclk = 1; cyc(4);
      sclk = 0;
    end
    cyc(4); sen = 0; cyc(12);
  endtask

  task automatic t_reset;
    chk("R1 c", c_word, 0); chk("R1 r", r_word, 0); chk("R1 a", a_word, 0);
    chk("R1 pend", {r_pending, a_pending}, 0); chk("R1 sdo", sdo, 0);
  endtask

  task automatic t_ctrl;
    send(8, 32'hA5);
    chk("R2 c", c_word, 32'hA5); chk("R2 nopend", {r_pending, a_pending}, 0);
  endtask

  task automatic t_ref_hold;
    int base = r_cnt;
    r_ready = 0; send(16, 32'h1234);
    chk("R3 pend", r_pending, 1); chk("R3 hold", r_word, 0);
    r_ready = 1; cyc(4);
    chk("R3 take", r_word, 32'h1234); chk("R3 clr", r_pending, 0);
    chk("R10 r pulses", r_cnt - base, 1);
  endtask

  task automatic t_main_hold;
    an_ready = 0; send(24, 32'hABCDEF);
    chk("R4 pend", a_pending, 1); chk("R4 hold", a_word, 0);
    chk("R8 sdo24", sdo, 1);
    send(2, 32'h0);
    chk("R8 sdo26", sdo, 1); chk("R5 2bit keep", a_pending, 1);
    sdi = 0;
    for (int i = 0; i < 8; i++) begin sclk = 1; cyc(4); sclk = 0; cyc(4); end
    cyc(8);
    chk("R9 sdo", sdo, 1); chk("R9 c", c_word, 32'hA5);
    an_ready = 1; cyc(4);
    chk("R4 take", a_word, 32'hABCDEF); chk("R4 clr", a_pending, 0);
  endtask

  task automatic t_replace;
    int base = a_cnt;
    an_ready = 0; send(24, 32'h111111); send(24, 32'h222222);
    an_ready = 1; cyc(4);
    chk("R7 last", a_word, 32'h222222); chk("R7 once", a_cnt - base, 1);
  endtask

  task automatic t_pair;
    int base = pair_cnt;
    an_ready = 0; r_ready = 0;
    send(16, 32'h5555); send(24, 32'h0F0F0F);
    an_ready = 1; cyc(6);
    chk("R6 a wait", a_word, 32'h222222); chk("R6 r wait", r_word, 32'h1234);
    r_ready = 1; cyc(4);
    chk("R6 a", a_word, 32'h0F0F0F); chk("R6 r", r_word, 32'h5555);
    chk("R6 same cycle", pair_cnt - base, 1);
  endtask

  task automatic t_lengths;
    send(7, 32'h7F); send(9, 32'h1FF); send(25, 32'h1FFFFFF); send(0, 32'h0);
    chk("R5 c", c_word, 32'hA5); chk("R5 r", r_word, 32'h5555);
    chk("R5 a", a_word, 32'h0F0F0F); chk("R5 pend", {r_pending, a_pending}, 0);
  endtask

  initial begin
    cyc(5); rst_n = 1; cyc(3);
    t_reset; t_ctrl; t_ref_hold; t_main_hold; t_replace; t_pair; t_lengths;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule